// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block picks the next fetch address for a small processor core that runs nested hardware loops with no branch cost. Each cycle it takes the address of the instruction now executing. When that address is the last one of the innermost active loop, it chooses between going back to the loop top and leaving the loop. Otherwise it chooses the next sequential address. The choice is made in the same cycle, so a loop costs no extra cycles per pass.

A loop-setup instruction raises `do_start_i` and supplies three values: the address of the loop's final instruction, a termination condition code and an iteration count. The block saves the return point (the setup address plus one) on a 16-entry address stack. It saves the end address, the condition and the count as one entry on a 4-entry loop stack. While the loop runs, the entries are only read. They are removed in the cycle the loop finishes. Outside logic can also push and pop the address stack for subroutine linkage, and it can read the top entry.

Top module: `hwl_seq`

## Requirements
- R1: After synchronous reset both stacks are empty, both overflow flags are low, and `next_pc_o` equals `pc_i + 1`.
- R2: When `do_start_i` is high, `next_pc_o` is `pc_i + 1`. At the clock edge, `pc_i + 1` is pushed onto the address stack, and {`do_end_i`, `do_cond_i`, `do_cnt_i`} is pushed onto the loop stack.
- R3: While the loop stack is empty, or `pc_i` differs from the end address of the top loop entry, `next_pc_o` is `pc_i + 1`.
- R4: When `pc_i` equals the top loop end address and the condition is false, `next_pc_o` is the top of the address stack. Neither stack changes depth, and `pc_top_o` is unchanged.
- R5: When `pc_i` equals the top loop end address and the condition is true, `next_pc_o` is `pc_i + 1`. The address stack and the loop stack each pop one entry in that cycle.
- R6: Condition code 15 means "count expired". It is true at the end instruction when the top count is 1. When it is false, the top count is decremented, so a count of N runs the body N times.
- R7: Condition codes 0 to 7 are true when `flags_i[code]` is 1. Codes 8 to 14 are true when `flags_i[code-8]` is 0.
- R8: Only the top loop entry is compared. When an inner loop exits, sequencing resumes inside the enclosing loop, and the enclosing loop keeps its own top address and count.
- R9: A push onto a full stack is dropped and sets that stack's overflow flag. The flag stays set until reset. A pop of an empty stack is ignored.
- R10: `ext_push_i` pushes `ext_data_i` onto the address stack and `ext_pop_i` pops it. `pc_top_o` shows the top entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 16 | Address of the executing instruction |
| do_start_i | input | 1 | Executing instruction sets up a loop |
| do_end_i | input | 16 | Last instruction address of the new loop |
| do_cond_i | input | 4 | Termination condition code of the new loop |
| do_cnt_i | input | 16 | Iteration count of the new loop |
| flags_i | input | 8 | Condition flags |
| ext_push_i | input | 1 | External push onto the address stack |
| ext_pop_i | input | 1 | External pop of the address stack |
| ext_data_i | input | 16 | Value for an external push |
| next_pc_o | output | 16 | Next fetch address |
| pc_top_o | output | 16 | Top of the address stack |
| pc_empty_o | output | 1 | Address stack empty |
| pc_ovf_o | output | 1 | Sticky address stack overflow |
| lp_empty_o | output | 1 | Loop stack empty |
| lp_ovf_o | output | 1 | Sticky loop stack overflow |

## Verification
The bench targets these corner cases:

- **One-pass loop (count 1).** A design that decrements before testing would loop back once too often.
- **Multi-pass counted loop.** A design that pops on loop-back would lose its top address after the first pass.
- **Two-level nesting with the inner loop entered twice.** A sequencer that compares something other than the top entry, or damages the outer entry on an inner exit, would jump to the wrong address.
- **Flag-terminated loops under both polarities.** These catch an inverted or misindexed flag select.
- **Overflow on both stacks, and a pop of an empty stack.** A design that overwrote an entry on overflow would show a wrong top, and one that dropped the sticky flag would lose the overflow record.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int FLAG_W = 8;
    localparam int FSEL_W = $clog2(FLAG_W);
    localparam int COND_W = FSEL_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [COND_W-1:0] cond_t;
    typedef logic [CNT_W-1:0]  count_t;

    // all-ones condition code selects the iteration counter
    localparam cond_t COND_CNT = '1;

    typedef struct packed {
        addr_t  end_addr;
        cond_t  cond;
        count_t count;
    } loop_ent_t;

    function automatic addr_t addr_inc(addr_t a);
        return a + addr_t'(1);
    endfunction
endpackage

// File: rtl/hwl_lifo.sv
module hwl_lifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       wr_top,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               top,
    output logic                       empty,
    output logic                       ovf,
    output logic [$clog2(DEPTH+1)-1:0] depth
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [DW-1:0] cnt;
    logic [DW-1:0] cnt_m1;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] wr_idx;

    assign cnt_m1  = cnt - 1'b1;
    assign top_idx = cnt_m1[IW-1:0];
    assign wr_idx  = cnt[IW-1:0];
    assign empty   = (cnt == '0);
    assign depth   = cnt;
    assign top     = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (push) begin
            if (cnt == DW'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                mem[wr_idx] <= din;
                cnt         <= cnt + 1'b1;
            end
        end else if (pop) begin
            if (!empty) cnt <= cnt_m1;
        end else if (wr_top && !empty) begin
            mem[top_idx] <= din;
        end
    end
endmodule

// File: rtl/hwl_cond_eval.sv
module hwl_cond_eval
    import hwl_pkg::*;
(
    input  cond_t               cond,
    input  logic [FLAG_W-1:0]   flags,
    input  count_t              count,
    output logic                term
);
    logic [FSEL_W-1:0] sel;
    assign sel = cond[FSEL_W-1:0];

    always_comb begin
        if (cond == COND_CNT)
            term = (count == count_t'(1));
        else if (cond[COND_W-1])
            term = !flags[sel];
        else
            term = flags[sel];
    end
endmodule

// File: rtl/hwl_seq.sv
module hwl_seq
    import hwl_pkg::*;
#(
    parameter int PC_DEPTH = 16,
    parameter int LP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       pc_i,
    input  logic              do_start_i,
    input  logic [15:0]       do_end_i,
    input  logic [3:0]        do_cond_i,
    input  logic [15:0]       do_cnt_i,
    input  logic [7:0]        flags_i,
    input  logic              ext_push_i,
    input  logic              ext_pop_i,
    input  logic [15:0]       ext_data_i,
    output logic [15:0]       next_pc_o,
    output logic [15:0]       pc_top_o,
    output logic              pc_empty_o,
    output logic              pc_ovf_o,
    output logic              lp_empty_o,
    output logic              lp_ovf_o
);
    localparam int PDW = $clog2(PC_DEPTH + 1);
    localparam int LDW = $clog2(LP_DEPTH + 1);
    localparam int LEW = $bits(loop_ent_t);

    loop_ent_t      lp_top;
    loop_ent_t      lp_din;
    logic           at_end;
    logic           term;
    logic           loop_back;
    logic           loop_exit;
    logic           cnt_dec;
    logic           pc_push;
    logic           pc_pop;
    addr_t          pc_din;
    addr_t          pc_inc;
    logic [PDW-1:0] pc_depth;
    logic [LDW-1:0] lp_depth;
    logic [LEW-1:0] lp_top_raw;

    assign pc_inc    = addr_inc(pc_i);
    assign lp_top    = loop_ent_t'(lp_top_raw);
    assign at_end    = !lp_empty_o && (pc_i == lp_top.end_addr);
    assign loop_back = at_end && !term;
    assign loop_exit = at_end && term;
    assign cnt_dec   = loop_back && (lp_top.cond == COND_CNT);

    // exit lands on end+1, which equals pc_i+1 here
    assign next_pc_o = loop_back ? pc_top_o : pc_inc;

    assign pc_push = do_start_i || ext_push_i;
    assign pc_pop  = loop_exit || ext_pop_i;
    assign pc_din  = do_start_i ? pc_inc : ext_data_i;

    always_comb begin
        if (do_start_i) begin
            lp_din.end_addr = do_end_i;
            lp_din.cond     = do_cond_i;
            lp_din.count    = do_cnt_i;
        end else begin
            lp_din       = lp_top;
            lp_din.count = lp_top.count - count_t'(1);
        end
    end

    hwl_cond_eval u_cond (
        .cond  (lp_top.cond),
        .flags (flags_i),
        .count (lp_top.count),
        .term  (term)
    );

    hwl_lifo #(.W(ADDR_W), .DEPTH(PC_DEPTH)) u_pc_stack (
        .clk    (clk),
        .rst    (rst),
        .push   (pc_push),
        .pop    (pc_pop),
        .wr_top (1'b0),
        .din    (pc_din),
        .top    (pc_top_o),
        .empty  (pc_empty_o),
        .ovf    (pc_ovf_o),
        .depth  (pc_depth)
    );

    hwl_lifo #(.W(LEW), .DEPTH(LP_DEPTH)) u_lp_stack (
        .clk    (clk),
        .rst    (rst),
        .push   (do_start_i),
        .pop    (loop_exit),
        .wr_top (cnt_dec),
        .din    (lp_din),
        .top    (lp_top_raw),
        .empty  (lp_empty_o),
        .ovf    (lp_ovf_o),
        .depth  (lp_depth)
    );
endmodule

// File: rtl/hwl_seq_chk.sv
module hwl_seq_chk #(
    parameter int PDW = 5,
    parameter int LDW = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [15:0]    pc_i,
    input logic [15:0]    next_pc_o,
    input logic           do_start_i,
    input logic           ext_push_i,
    input logic           ext_pop_i,
    input logic [15:0]    pc_top_o,
    input logic           pc_empty_o,
    input logic           pc_ovf_o,
    input logic           lp_empty_o,
    input logic           lp_ovf_o,
    input logic           loop_back,
    input logic           loop_exit,
    input logic [PDW-1:0] pc_depth,
    input logic [LDW-1:0] lp_depth
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_empty_o && lp_empty_o && !pc_ovf_o && !lp_ovf_o));

    a_r3_no_loop_seq: assert property (@(posedge clk) disable iff (rst)
        lp_empty_o |-> (next_pc_o == pc_i + 16'd1));

    a_r2_do_pushes: assert property (@(posedge clk) disable iff (rst)
        (do_start_i && !ext_push_i && !lp_ovf_o && !pc_ovf_o &&
         lp_depth < LDW'(4) && pc_depth < PDW'(16))
        |=> (!lp_empty_o && pc_top_o == $past(pc_i) + 16'd1));

    a_r4_loopback_keeps: assert property (@(posedge clk) disable iff (rst)
        (loop_back && !do_start_i && !ext_push_i && !ext_pop_i)
        |=> ($stable(pc_top_o) && $stable(pc_depth) && $stable(lp_depth)));

    a_r5_exit_pops: assert property (@(posedge clk) disable iff (rst)
        (loop_exit && !do_start_i && !ext_push_i && !ext_pop_i)
        |=> (lp_depth == $past(lp_depth) - LDW'(1) &&
             pc_depth == $past(pc_depth) - PDW'(1)));

    a_r9_pc_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        pc_ovf_o |=> pc_ovf_o);

    a_r9_lp_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        lp_ovf_o |=> lp_ovf_o);
endmodule

bind hwl_seq hwl_seq_chk #(.PDW(PDW), .LDW(LDW)) u_hwl_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_i       (pc_i),
    .next_pc_o  (next_pc_o),
    .do_start_i (do_start_i),
    .ext_push_i (ext_push_i),
    .ext_pop_i  (ext_pop_i),
    .pc_top_o   (pc_top_o),
    .pc_empty_o (pc_empty_o),
    .pc_ovf_o   (pc_ovf_o),
    .lp_empty_o (lp_empty_o),
    .lp_ovf_o   (lp_ovf_o),
    .loop_back  (loop_back),
    .loop_exit  (loop_exit),
    .pc_depth   (pc_depth),
    .lp_depth   (lp_depth)
);

// File: tb/hwl_seq_bench.sv
`timescale 1ns/1ps
module hwl_seq_bench;
    localparam logic [3:0] CCNT = 4'hF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc_i = '0;
    logic        do_start_i = 1'b0;
    logic [15:0] do_end_i = '0;
    logic [3:0]  do_cond_i = '0;
    logic [15:0] do_cnt_i = '0;
    logic [7:0]  flags_i = '0;
    logic        ext_push_i = 1'b0;
    logic        ext_pop_i = 1'b0;
    logic [15:0] ext_data_i = '0;
    logic [15:0] next_pc_o, pc_top_o;
    logic        pc_empty_o, pc_ovf_o, lp_empty_o, lp_ovf_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hwl_seq u_hwl_seq (
        .clk(clk), .rst(rst), .pc_i(pc_i), .do_start_i(do_start_i),
        .do_end_i(do_end_i), .do_cond_i(do_cond_i), .do_cnt_i(do_cnt_i),
        .flags_i(flags_i), .ext_push_i(ext_push_i), .ext_pop_i(ext_pop_i),
        .ext_data_i(ext_data_i), .next_pc_o(next_pc_o), .pc_top_o(pc_top_o),
        .pc_empty_o(pc_empty_o), .pc_ovf_o(pc_ovf_o),
        .lp_empty_o(lp_empty_o), .lp_ovf_o(lp_ovf_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one executing instruction, check the chosen next address
    task automatic step(input logic [15:0] pc, input logic dos, input logic [15:0] e,
                        input logic [3:0] c, input logic [15:0] n,
                        input logic [7:0] fl, input logic [15:0] exp, input string tag);
        @(negedge clk);
        pc_i = pc; do_start_i = dos; do_end_i = e; do_cond_i = c;
        do_cnt_i = n; flags_i = fl; ext_push_i = 1'b0; ext_pop_i = 1'b0;
        #1 chk(tag, next_pc_o, exp);
    endtask

    task automatic run(input logic [15:0] pc, input logic [7:0] fl,
                       input logic [15:0] exp, input string tag);
        step(pc, 1'b0, '0, '0, '0, fl, exp, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        pc_i = 16'hFF00; do_start_i = 1'b0; ext_push_i = 1'b0; ext_pop_i = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; do_start_i = 1'b0; ext_push_i = 1'b0; ext_pop_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        idle();
        chk("R1 pc stack empty", 16'(pc_empty_o), 16'd1);
        chk("R1 loop stack empty", 16'(lp_empty_o), 16'd1);
        chk("R1 overflow flags", {14'd0, pc_ovf_o, lp_ovf_o}, 16'd0);
        run(16'd5, 8'h00, 16'd6, "R1 R3 sequential after reset");
    endtask

    task automatic t_single();
        do_reset();
        step(16'd10, 1'b1, 16'd12, CCNT, 16'd1, 8'h00, 16'd11, "R2 loop setup next");
        idle();
        chk("R2 return address pushed", pc_top_o, 16'd11);
        chk("R2 loop entry pushed", 16'(lp_empty_o), 16'd0);
        run(16'd11, 8'h00, 16'd12, "R3 body sequential");
        run(16'd12, 8'h00, 16'd13, "R6 count 1 single pass exit");
        idle();
        chk("R5 pc stack popped", 16'(pc_empty_o), 16'd1);
        chk("R5 loop stack popped", 16'(lp_empty_o), 16'd1);
    endtask

    task automatic t_counted();
        do_reset();
        step(16'd20, 1'b1, 16'd22, CCNT, 16'd3, 8'h00, 16'd21, "R2 counted setup");
        for (int p = 0; p < 3; p++) begin
            run(16'd21, 8'h00, 16'd22, "R3 counted body");
            run(16'd22, 8'h00, (p == 2) ? 16'd23 : 16'd21, "R6 counted end");
            if (p < 2) begin
                idle();
                chk("R4 top kept on loop back", pc_top_o, 16'd21);
                chk("R4 loop stack kept", 16'(lp_empty_o), 16'd0);
            end
        end
        idle();
        chk("R5 counted exit pops", {14'd0, pc_empty_o, lp_empty_o}, 16'd3);
    endtask

    task automatic t_nested();
        do_reset();
        step(16'd30, 1'b1, 16'd36, CCNT, 16'd2, 8'h00, 16'd31, "R8 outer setup");
        for (int o = 0; o < 2; o++) begin
            step(16'd31, 1'b1, 16'd34, CCNT, 16'd2, 8'h00, 16'd32, "R8 inner setup");
            for (int i = 0; i < 2; i++) begin
                run(16'd32, 8'h00, 16'd33, "R8 inner body");
                run(16'd33, 8'h00, 16'd34, "R8 inner body");
                run(16'd34, 8'h00, (i == 1) ? 16'd35 : 16'd32, "R8 inner end");
            end
            idle();
            chk("R8 outer top restored", pc_top_o, 16'd31);
            run(16'd35, 8'h00, 16'd36, "R8 outer body");
            run(16'd36, 8'h00, (o == 1) ? 16'd37 : 16'd31, "R8 outer end");
        end
        idle();
        chk("R8 all popped", {14'd0, pc_empty_o, lp_empty_o}, 16'd3);
    endtask

    task automatic t_flags();
        do_reset();
        // code 2: true when flag 2 is 1
        step(16'd40, 1'b1, 16'd41, 4'd2, 16'd0, 8'h00, 16'd41, "R7 flag loop setup");
        run(16'd41, 8'hFB, 16'd41, "R7 flag 2 clear loops back");
        run(16'd41, 8'h00, 16'd41, "R7 flag 2 clear loops back");
        run(16'd41, 8'h04, 16'd42, "R7 flag 2 set exits");
        // code 11: true when flag 3 is 0
        step(16'd50, 1'b1, 16'd52, 4'd11, 16'd0, 8'h08, 16'd51, "R7 inverted setup");
        run(16'd51, 8'h08, 16'd52, "R7 inverted body");
        run(16'd52, 8'h08, 16'd51, "R7 flag 3 set loops back");
        run(16'd51, 8'h00, 16'd52, "R7 inverted body");
        run(16'd52, 8'h00, 16'd53, "R7 flag 3 clear exits");
        idle();
        chk("R7 flag loops popped", {14'd0, pc_empty_o, lp_empty_o}, 16'd3);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 0; k < 5; k++)
            step(16'(100 + k), 1'b1, 16'(200 + k), CCNT, 16'd1, 8'h00,
                 16'(101 + k), "R2 deep setup");
        idle();
        chk("R9 loop overflow set", 16'(lp_ovf_o), 16'd1);
        chk("R9 pc stack no overflow", 16'(pc_ovf_o), 16'd0);
        // fifth entry dropped: top loop ends at 203
        run(16'd204, 8'h00, 16'd205, "R9 dropped entry not compared");
        run(16'd203, 8'h00, 16'd204, "R9 fourth entry on top exits");
        idle();
        chk("R9 loop overflow sticky", 16'(lp_ovf_o), 16'd1);
        do_reset();
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            ext_push_i = 1'b1; ext_data_i = 16'(16'h700 + k);
        end
        idle();
        chk("R9 pc overflow set", 16'(pc_ovf_o), 16'd1);
        chk("R9 overflowing push dropped", pc_top_o, 16'h70F);
    endtask

    task automatic t_ext();
        do_reset();
        @(negedge clk);
        ext_push_i = 1'b1; ext_data_i = 16'h0055;
        @(negedge clk);
        ext_data_i = 16'h0066;
        idle();
        chk("R10 external push top", pc_top_o, 16'h0066);
        @(negedge clk);
        ext_pop_i = 1'b1;
        idle();
        chk("R10 external pop top", pc_top_o, 16'h0055);
        @(negedge clk);
        ext_pop_i = 1'b1;
        @(negedge clk);
        ext_pop_i = 1'b1;
        idle();
        chk("R9 pop of empty ignored", 16'(pc_empty_o), 16'd1);
        @(negedge clk);
        ext_push_i = 1'b1; ext_data_i = 16'h0077;
        idle();
        chk("R9 stack usable after empty pop", pc_top_o, 16'h0077);
    endtask

    initial begin
        t_reset();
        t_single();
        t_counted();
        t_nested();
        t_flags();
        t_overflow();
        t_ext();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule